// File: doc/BRIEF.md
# Hardware Loop Counter with Expiry Flag

This block counts the passes of a hardware loop. Before a counted loop starts, software writes the wanted number of iterations into a 14-bit unsigned count register over a 16-bit data bus. At the end of each pass, the sequencer pulses a decrement strobe. In that cycle it reads the expiry flag to decide whether to leave the loop, and the count drops by one on the same clock edge.

The register takes the true iteration count N, not N-1. The expiry flag is decoded from the value 1. Because the flag is tested before the decrement, the loop body runs exactly N times.

A small last-in first-out count stack supports nested loops. A push saves the outer loop's count before the inner count is loaded. A pop restores the outer count when the inner loop finishes. Two sticky flags record a push onto a full stack and a pop from an empty stack.

Top module: `loop_counter_unit`

## Requirements
- R1: After reset the count reads 0, the expiry flag is 0, the stack reports empty, and both sticky error flags are 0.
- R2: A load strobe writes bits 13:0 of the data bus into the count at the next clock edge. Bus bits 15:14 have no effect on the count.
- R3: The expiry flag is 1 exactly when the count equals 1. It is 0 for every other value, including 0.
- R4: A decrement strobe lowers the count by one at the clock edge that ends the cycle. The expiry flag seen during that cycle reflects the value before the decrement. A count of 0 wraps to 16383.
- R5: When load and decrement (or load and pop) are strobed in the same cycle, the loaded value wins.
- R6: After a load of N (1 to 16383), repeatedly sampling the flag and decrementing gives exactly N passes up to and including the first pass that sees the flag at 1.
- R7: A push saves the current count on the 4-entry stack without changing the count. A pop copies the most recently saved value into the count and removes it. Order is last-in first-out.
- R8: A push with 4 entries already stored is dropped, and the overflow flag becomes 1. The flag stays 1 until reset.
- R9: A pop with the stack empty leaves the count and the stack unchanged, and the underflow flag becomes 1. The flag stays 1 until reset.
- R10: When push and pop are strobed together, the push takes effect and the pop is ignored.
- R11: When pop and decrement are strobed together on a non-empty stack, the restored value wins over the decrement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| load_en | input | 1 | Load the count from the data bus |
| load_bus | input | 16 | Data bus; the low 14 bits are the count |
| dec_en | input | 1 | End-of-pass test strobe; decrements the count |
| push_en | input | 1 | Save the current count on the stack |
| pop_en | input | 1 | Restore the count from the stack |
| count_o | output | 14 | Current count value |
| expired_o | output | 1 | Count equals 1 |
| stk_empty_o | output | 1 | Stack holds no entries |
| stk_ovf_o | output | 1 | Sticky: push attempted while full |
| stk_udf_o | output | 1 | Sticky: pop attempted while empty |

## Verification
The bench uses the default parameters: a 14-bit count, a 16-bit bus and a 4-entry stack. At that size, every one of the 16384 count values can be loaded (with random upper bus bits) and then decremented, so the 0-to-16383 wrap and the single value that raises the flag fall inside the sweep. Loop runs for N from 1 to 40 confirm the pass count. The 4-deep stack is small enough to fill past its limit and drain past empty, which reaches both sticky flags and every strobe-collision priority.

// File: rtl/loopctr_pkg.sv
package loopctr_pkg;
  localparam int LC_CNT_W     = 14;
  localparam int LC_BUS_W     = 16;
  localparam int LC_STK_DEPTH = 4;

  typedef enum logic [1:0] {
    SRC_HOLD = 2'd0,
    SRC_LOAD = 2'd1,
    SRC_POP  = 2'd2,
    SRC_DEC  = 2'd3
  } cnt_src_e;
endpackage

// File: rtl/loopctr_stack.sv
module loopctr_stack #(
  parameter int W     = 14,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] top_o,
  output logic         empty_o,
  output logic         pop_ok_o,
  output logic         ovf_o,
  output logic         udf_o
);
  localparam int LW = $clog2(DEPTH + 1);
  localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

  logic [LW-1:0] level_q, level_d;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic          full, do_push, do_pop;
  logic [W-1:0]  mem_q [DEPTH];

  assign full    = (level_q == FULL_LVL);
  assign empty_o = (level_q == '0);
  assign do_push = push_i & ~full;
  assign do_pop  = pop_i & ~push_i & ~empty_o;
  assign pop_ok_o = do_pop;

  always_comb begin
    level_d = level_q;
    if (do_push)     level_d = level_q + 1'b1;
    else if (do_pop) level_d = level_q - 1'b1;
    ovf_d = ovf_q | (push_i & full);
    udf_d = udf_q | (pop_i & ~push_i & empty_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      ovf_q   <= 1'b0;
      udf_q   <= 1'b0;
    end else begin
      level_q <= level_d;
      ovf_q   <= ovf_d;
      udf_q   <= udf_d;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic wr_en;
    assign wr_en = do_push & (level_q == LW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     mem_q[i] <= '0;
      else if (wr_en) mem_q[i] <= wdata_i;
    end
  end

  always_comb begin
    top_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (level_q == LW'(i + 1)) top_o = mem_q[i];
    end
  end

  assign ovf_o = ovf_q;
  assign udf_o = udf_q;

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= FULL_LVL); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R8
  AST_UDF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    udf_q |=> udf_q); // R9
  AST_FULL_PUSH_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && full) |=> (level_q == FULL_LVL) && ovf_q); // R8
  AST_PUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && pop_i && !full) |=> level_q == $past(level_q) + 1'b1); // R10
endmodule

// File: rtl/loopctr_core.sv
module loopctr_core
  import loopctr_pkg::*;
#(
  parameter int CNT_W = 14,
  parameter int BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [BUS_W-1:0] bus_i,
  input  logic             restore_i,
  input  logic [CNT_W-1:0] restore_val_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] count_o,
  output logic             expired_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  cnt_src_e         src;
  logic [CNT_W-1:0] count_q, count_d;
  logic             cnt_en;

  always_comb begin
    if (load_i)         src = SRC_LOAD;
    else if (restore_i) src = SRC_POP;
    else if (dec_i)     src = SRC_DEC;
    else                src = SRC_HOLD;
  end

  assign cnt_en = (src != SRC_HOLD);

  always_comb begin
    unique case (src)
      SRC_LOAD: count_d = bus_i[CNT_W-1:0];
      SRC_POP:  count_d = restore_val_i;
      SRC_DEC:  count_d = count_q - ONE;
      default:  count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_q <= '0;
    else if (cnt_en) count_q <= count_d;
  end

  assign count_o   = count_q;
  assign expired_o = (count_q == ONE);

  AST_LOAD_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_q == $past(bus_i[CNT_W-1:0])); // R2
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !restore_i) |=> count_q == $past(count_q) - ONE); // R4
  AST_TWO_TO_EXPIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_i && !load_i && !restore_i && count_q == CNT_W'(2)) |=> expired_o); // R3
  AST_POP_OVER_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_i && !load_i) |=> count_q == $past(restore_val_i)); // R11
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !restore_i && !dec_i) |=> $stable(count_q)); // R7
endmodule

// File: rtl/loop_counter_unit.sv
module loop_counter_unit
  import loopctr_pkg::*;
#(
  parameter int CNT_W     = LC_CNT_W,
  parameter int BUS_W     = LC_BUS_W,
  parameter int STK_DEPTH = LC_STK_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_en,
  input  logic [BUS_W-1:0] load_bus,
  input  logic             dec_en,
  input  logic             push_en,
  input  logic             pop_en,
  output logic [CNT_W-1:0] count_o,
  output logic             expired_o,
  output logic             stk_empty_o,
  output logic             stk_ovf_o,
  output logic             stk_udf_o
);
  logic             rst_meta_q, rst_sync_q;
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] stk_top;
  logic             pop_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  loopctr_stack #(.W(CNT_W), .DEPTH(STK_DEPTH)) u_stack (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .push_i   (push_en),
    .pop_i    (pop_en),
    .wdata_i  (count),
    .top_o    (stk_top),
    .empty_o  (stk_empty_o),
    .pop_ok_o (pop_ok),
    .ovf_o    (stk_ovf_o),
    .udf_o    (stk_udf_o)
  );

  loopctr_core #(.CNT_W(CNT_W), .BUS_W(BUS_W)) u_core (
    .clk           (clk),
    .rst_n         (rst_sync_q),
    .load_i        (load_en),
    .bus_i         (load_bus),
    .restore_i     (pop_ok),
    .restore_val_i (stk_top),
    .dec_i         (dec_en),
    .count_o       (count),
    .expired_o     (expired_o)
  );

  assign count_o = count;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    $rose(rst_sync_q) |-> (count == '0) && stk_empty_o && !stk_ovf_o && !stk_udf_o); // R1
  AST_EMPTY_POP_KEEP: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (pop_en && !push_en && stk_empty_o && !load_en && !dec_en) |=> $stable(count) && stk_udf_o); // R9
  AST_PUSH_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (push_en && !load_en && !dec_en) |=> $stable(count)); // R7
endmodule

// File: tb/tb_loop_counter_unit.sv
module tb_loop_counter_unit;
  localparam int W = 14;
  localparam int D = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          load_en, dec_en, push_en, pop_en;
  logic [15:0]   load_bus;
  logic [W-1:0]  count_o;
  logic          expired_o, stk_empty_o, stk_ovf_o, stk_udf_o;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] m_cnt;
  logic [W-1:0] m_stk [D];
  int           m_lvl;
  logic         m_ovf, m_udf;

  always #10 clk = ~clk;

  loop_counter_unit dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_bus(load_bus),
    .dec_en(dec_en), .push_en(push_en), .pop_en(pop_en),
    .count_o(count_o), .expired_o(expired_o), .stk_empty_o(stk_empty_o),
    .stk_ovf_o(stk_ovf_o), .stk_udf_o(stk_udf_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk({req, " count"}, int'(count_o), int'(m_cnt));
    chk({req, " expired"}, int'(expired_o), int'(m_cnt == W'(1)));
    chk({req, " flags"}, int'({stk_empty_o, stk_ovf_o, stk_udf_o}),
        int'({m_lvl == 0, m_ovf, m_udf}));
  endtask

  // drive one cycle (called at a falling edge), update model, check after the edge
  task automatic apply(input logic l, input logic [15:0] d, input logic dc,
                       input logic pu, input logic po, input string req);
    logic [W-1:0] nxt;
    logic         pop_ok;
    logic [W-1:0] popv;
    pop_ok = po && !pu && (m_lvl != 0);
    popv   = (m_lvl != 0) ? m_stk[m_lvl-1] : '0;
    if (l)           nxt = d[W-1:0];
    else if (pop_ok) nxt = popv;
    else if (dc)     nxt = m_cnt - W'(1);
    else             nxt = m_cnt;
    if (pu) begin
      if (m_lvl < D) begin m_stk[m_lvl] = m_cnt; m_lvl++; end
      else m_ovf = 1'b1;
    end else if (po) begin
      if (m_lvl == 0) m_udf = 1'b1;
      else m_lvl--;
    end
    m_cnt = nxt;
    load_en = l; load_bus = d; dec_en = dc; push_en = pu; pop_en = po;
    @(negedge clk);
    load_en = 0; dec_en = 0; push_en = 0; pop_en = 0;
    check_all(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int passes;
    logic seen;
    rst_n = 1'b0; load_en = 0; dec_en = 0; push_en = 0; pop_en = 0; load_bus = '0;
    m_cnt = '0; m_lvl = 0; m_ovf = 0; m_udf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check_all("R1 reset");
    chk("R3 zero not expired", int'(expired_o), 0);

    // R2 R4 R3: sweep every count value, upper bus bits random
    for (int v = 0; v < (1 << W); v++) begin
      apply(1, {2'($urandom), W'(v)}, 0, 0, 0, "R2 load sweep");
      apply(0, '0, 1, 0, 0, "R4 dec sweep");
    end
    apply(1, 16'hC000, 0, 0, 0, "R2 upper bits only");
    apply(0, '0, 1, 0, 0, "R4 wrap 0");
    chk("R4 wrap value", int'(count_o), (1 << W) - 1);

    // R6: N passes
    for (int n = 1; n <= 40; n++) begin
      apply(1, 16'(n), 0, 0, 0, "R6 load");
      passes = 0;
      do begin
        passes++;
        seen = expired_o;
        apply(0, '0, 1, 0, 0, "R6 pass");
      end while (!seen && passes < 100);
      chk("R6 pass count", passes, n);
    end

    // R5 priority
    apply(1, 16'd7, 0, 0, 0, "R5 setup");
    apply(1, 16'd100, 1, 0, 0, "R5 load over dec");
    chk("R5 load over dec value", int'(count_o), 100);

    // R7 R8: fill stack past its limit
    for (int i = 0; i < D + 1; i++) begin
      apply(1, 16'(10 + i), 0, 0, 0, "R7 load before push");
      apply(0, '0, 0, 1, 0, "R7 R8 push");
    end
    chk("R8 overflow set", int'(stk_ovf_o), 1);
    apply(1, 16'd500, 0, 0, 1, "R5 load over pop");
    chk("R5 load over pop value", int'(count_o), 500);
    apply(0, '0, 1, 0, 1, "R11 pop over dec");
    chk("R11 pop value", int'(count_o), 12);
    apply(1, 16'd77, 0, 0, 0, "R10 setup");
    apply(0, '0, 0, 1, 1, "R10 push and pop");
    chk("R10 count kept", int'(count_o), 77);
    for (int i = 0; i < D + 1; i++) apply(0, '0, 0, 0, 1, "R7 R9 pop drain");
    chk("R9 underflow set", int'(stk_udf_o), 1);
    apply(1, 16'd33, 0, 0, 0, "R9 setup");
    apply(0, '0, 0, 0, 1, "R9 empty pop keeps count");
    chk("R9 count kept", int'(count_o), 33);
    apply(0, '0, 0, 1, 0, "R8 sticky after push");
    chk("R8 ovf still set", int'(stk_ovf_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule